// File: doc/BRIEF.md
# Two-Cycle Wormhole Mesh Router

This block is a packet-switched wormhole router for a two-dimensional mesh. It has five flit channels: one local channel plus one toward each neighbour. Each input channel feeds a small flit queue whose read and write pointers show whether a flit is waiting. Each output channel has its own controller. The controller picks one waiting head flit by round-robin and keeps the output reserved for that packet until the packet's last flit has gone. It also tracks free buffer slots in the next router as credits. A crossbar with one five-to-one multiplexer per output carries the chosen flit to a registered output.

A head flit carries the output it must take at this router in a three-bit output field. Upstream routing has already worked out this field, so the controllers can start arbitration as soon as the flit is queued. In the same cycle, a lookahead unit on each output works out the route for the neighbour router, using X-then-Y ordering. It rewrites the field in the departing head. A flit that arrives in one cycle is queued at the first clock edge and leaves through the output register at the second edge. The hop therefore costs exactly two cycles when the output is free and holds a credit. Packets have any length. A single-flit packet is both head and tail.

Each output controller has two states. In IDLE it arbitrates. Granting a head that is not also a tail moves it to ACTIVE. Granting a single-flit packet keeps it in IDLE. In ACTIVE it forwards only the owner's flits, and sending the owner's tail returns it to IDLE.

Top module: `wh_router2`

## Requirements
- R1: While reset is held and in the first cycle after it, every out_valid and every in_credit bit is 0.
- R2: A flit driven on an input with valid in cycle k appears on its output in cycle k+2, payload unchanged, when the output is idle and has a credit.
- R3: A head flit leaves on the output named by its bits [2:0], coded 0 local, 1 east (x+1), 2 west (x-1), 3 north (y+1), 4 south (y-1). Flit bits [17:16] give the kind: 01 head, 00 body, 10 tail, 11 single.
- R4: A departing head has bits [2:0] replaced by the X-then-Y route at the neighbour router. The destination x is in bits [4:3] and y in bits [6:5]. X is corrected first, and an equal destination selects 0. A head leaving on the local output carries 0.
- R5: Once an output grants a multi-flit packet, it carries only that packet's flits, in order, until its tail has been sent. Competing heads wait.
- R6: Heads competing for one idle output are granted round-robin, starting after the input granted last on that output.
- R7: Each output starts with DOWN_DEPTH credits. It spends one per flit and regains one per out_credit pulse. It sends nothing while its count is zero, and it resumes two cycles after a credit pulse.
- R8: Each flit leaving an input queue raises that input's in_credit for exactly one cycle, in the same cycle the flit appears at its output.
- R9: Each input queues up to BUF_DEPTH flits while its output is blocked and releases them in arrival order.
- R10: A single-flit packet frees its output at once, so queued single flits from different inputs leave on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Per-input flit strobe |
| in_flit | input | 90 | Five 18-bit input flits, input p at bits [18p+17:18p] |
| in_credit | output | 5 | Per-input one-cycle pulse when a queued flit departs |
| out_valid | output | 5 | Per-output flit strobe |
| out_flit | output | 90 | Five 18-bit output flits, output p at bits [18p+17:18p] |
| out_credit | input | 5 | Per-output credit return from the next router |

## Verification
Some properties are checked by assertions on every cycle. The queues never accept a flit while full and never pop while empty. Credit counts stay within their limit. An ACTIVE output keeps its owner. The queue pops match the grants, the input credit pulses match the output strobes, and local-port heads carry output code 0. Other behaviours only the bench's scenarios can show: the exact two-cycle latency, the lookahead rewrite for every destination, round-robin order, the stall and restart timing around a credit pulse, and the order of flits held in a queue. The bench sends a single flit from every input to every destination in a 3x3 mesh, then builds contention, credit starvation and full-queue cases.

// File: rtl/wh_router_pkg.sv
package wh_router_pkg;

    localparam int NPORT     = 5;
    localparam int PORT_W    = 3;
    localparam int COORD_W   = 2;
    localparam int PAYLOAD_W = 16;
    localparam int FLIT_W    = PAYLOAD_W + 2;
    localparam int OPEN_BIT  = FLIT_W - 2;
    localparam int CLOSE_BIT = FLIT_W - 1;
    localparam int DX_LSB    = PORT_W;
    localparam int DY_LSB    = PORT_W + COORD_W;

    localparam logic [PORT_W-1:0] PORT_LOCAL = 3'd0;
    localparam logic [PORT_W-1:0] PORT_EAST  = 3'd1;
    localparam logic [PORT_W-1:0] PORT_WEST  = 3'd2;
    localparam logic [PORT_W-1:0] PORT_NORTH = 3'd3;
    localparam logic [PORT_W-1:0] PORT_SOUTH = 3'd4;

    typedef enum logic {
        OUT_IDLE   = 1'b0,
        OUT_ACTIVE = 1'b1
    } out_state_e;

    // X is resolved before Y; equal coordinates eject locally.
    function automatic logic [PORT_W-1:0] xy_route(
        input logic [COORD_W-1:0] cx,
        input logic [COORD_W-1:0] cy,
        input logic [COORD_W-1:0] dx,
        input logic [COORD_W-1:0] dy
    );
        if (dx > cx)      return PORT_EAST;
        else if (dx < cx) return PORT_WEST;
        else if (dy > cy) return PORT_NORTH;
        else if (dy < cy) return PORT_SOUTH;
        else              return PORT_LOCAL;
    endfunction

endpackage

// File: rtl/wh_input_port.sv
module wh_input_port
    import wh_router_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FLIT_W-1:0] wr_flit,
    input  logic              pop,
    output logic              front_valid,
    output logic [FLIT_W-1:0] front_flit,
    output logic              credit_ret
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PTR_W = IDX_W + 1;

    logic [FLIT_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  rd_ptr;
    logic [PTR_W-1:0]  wr_ptr;
    logic              empty;
    logic              full;

    always_comb begin
        empty = (rd_ptr == wr_ptr);
        full  = (rd_ptr[IDX_W] != wr_ptr[IDX_W]) &&
                (rd_ptr[IDX_W-1:0] == wr_ptr[IDX_W-1:0]);
        front_valid = !empty;
        front_flit  = slots[rd_ptr[IDX_W-1:0]];
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full) begin
            slots[wr_ptr[IDX_W-1:0]] <= wr_flit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr     <= '0;
            wr_ptr     <= '0;
            credit_ret <= 1'b0;
        end else begin
            if (wr_en && !full) begin
                wr_ptr <= wr_ptr + PTR_W'(1);
            end
            if (pop && !empty) begin
                rd_ptr <= rd_ptr + PTR_W'(1);
            end
            credit_ret <= pop && !empty;
        end
    end

    // R9: upstream must respect credits, so a write never meets a full queue
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);

    // R8: a departure is only ever requested for a queued flit
    assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/wh_lookahead.sv
module wh_lookahead
    import wh_router_pkg::*;
#(
    parameter int OUT_PORT = 0,
    parameter int MY_X     = 1,
    parameter int MY_Y     = 1
) (
    input  logic [FLIT_W-1:0] flit_in,
    output logic [FLIT_W-1:0] flit_out
);

    localparam int NX_I = MY_X + ((OUT_PORT == 1) ? 1 : 0) - ((OUT_PORT == 2) ? 1 : 0);
    localparam int NY_I = MY_Y + ((OUT_PORT == 3) ? 1 : 0) - ((OUT_PORT == 4) ? 1 : 0);
    localparam logic [COORD_W-1:0] NX = NX_I[COORD_W-1:0];
    localparam logic [COORD_W-1:0] NY = NY_I[COORD_W-1:0];

    logic [PORT_W-1:0]  next_oc;
    logic [COORD_W-1:0] dest_x;
    logic [COORD_W-1:0] dest_y;

    assign dest_x = flit_in[DX_LSB +: COORD_W];
    assign dest_y = flit_in[DY_LSB +: COORD_W];

    generate
        if (OUT_PORT == 0) begin : g_eject
            assign next_oc = PORT_LOCAL;
        end else begin : g_hop
            assign next_oc = xy_route(NX, NY, dest_x, dest_y);
        end
    endgenerate

    always_comb begin
        flit_out = flit_in;
        if (flit_in[OPEN_BIT]) begin
            flit_out[PORT_W-1:0] = next_oc;
        end
    end

endmodule

// File: rtl/wh_out_ctrl.sv
module wh_out_ctrl
    import wh_router_pkg::*;
#(
    parameter int NIN      = NPORT,
    parameter int CRED_MAX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIN-1:0]    head_req,
    input  logic [NIN-1:0]    front_valid,
    input  logic [NIN-1:0]    front_last,
    input  logic              credit_ret,
    output logic              send,
    output logic [PORT_W-1:0] sel
);

    localparam int CRED_W = $clog2(CRED_MAX + 1);

    out_state_e        state_q, state_d;
    logic [PORT_W-1:0] owner_q, owner_d;
    logic [PORT_W-1:0] last_q, last_d;
    logic [CRED_W-1:0] cred_q, cred_d;
    logic              any_req;
    logic [PORT_W-1:0] winner;

    // Round-robin search starting after the last granted input.
    always_comb begin
        any_req = 1'b0;
        winner  = '0;
        for (int k = 1; k <= NIN; k++) begin
            int idx;
            idx = (int'(last_q) + k) % NIN;
            if (!any_req && head_req[idx]) begin
                any_req = 1'b1;
                winner  = PORT_W'(idx);
            end
        end
    end

    // Output and next-state process.
    always_comb begin
        send    = 1'b0;
        sel     = owner_q;
        state_d = state_q;
        owner_d = owner_q;
        last_d  = last_q;
        unique case (state_q)
            OUT_IDLE: begin
                if (any_req && cred_q != '0) begin
                    send    = 1'b1;
                    sel     = winner;
                    owner_d = winner;
                    last_d  = winner;
                    if (!front_last[winner]) begin
                        state_d = OUT_ACTIVE;
                    end
                end
            end
            OUT_ACTIVE: begin
                if (front_valid[owner_q] && cred_q != '0) begin
                    send = 1'b1;
                    if (front_last[owner_q]) begin
                        state_d = OUT_IDLE;
                    end
                end
            end
            default: state_d = OUT_IDLE;
        endcase
    end

    always_comb begin
        cred_d = cred_q;
        if (send && !credit_ret) begin
            cred_d = cred_q - CRED_W'(1);
        end else if (!send && credit_ret) begin
            cred_d = cred_q + CRED_W'(1);
        end
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
            owner_q <= '0;
            last_q  <= PORT_W'(NIN - 1);
            cred_q  <= CRED_W'(CRED_MAX);
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            last_q  <= last_d;
            cred_q  <= cred_d;
        end
    end

    // R7: returned credits never exceed the downstream buffer depth
    assert_credit_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cred_q <= CRED_W'(CRED_MAX));

    // R5: an output stays with one packet for as long as it is reserved
    assert_owner_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OUT_ACTIVE && $past(state_q) == OUT_ACTIVE) |-> owner_q == $past(owner_q));

endmodule

// File: rtl/wh_router2.sv
module wh_router2
    import wh_router_pkg::*;
#(
    parameter int MY_X       = 1,
    parameter int MY_Y       = 1,
    parameter int BUF_DEPTH  = 4,
    parameter int DOWN_DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT-1:0]        in_valid,
    input  logic [NPORT*FLIT_W-1:0] in_flit,
    output logic [NPORT-1:0]        in_credit,
    output logic [NPORT-1:0]        out_valid,
    output logic [NPORT*FLIT_W-1:0] out_flit,
    input  logic [NPORT-1:0]        out_credit
);

    logic [NPORT-1:0]  front_valid;
    logic [FLIT_W-1:0] front_flit [NPORT];
    logic [NPORT-1:0]  front_last;
    logic [NPORT-1:0]  pop;
    logic [NPORT-1:0]  head_req [NPORT];
    logic [NPORT-1:0]  send;
    logic [PORT_W-1:0] sel [NPORT];
    logic [FLIT_W-1:0] xbar_flit [NPORT];
    logic [FLIT_W-1:0] la_flit [NPORT];

    // Stage one: queue the arriving flit.
    generate
        for (genvar gi = 0; gi < NPORT; gi++) begin : g_in
            wh_input_port #(.DEPTH(BUF_DEPTH)) u_port (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_en      (in_valid[gi]),
                .wr_flit    (in_flit[gi*FLIT_W +: FLIT_W]),
                .pop        (pop[gi]),
                .front_valid(front_valid[gi]),
                .front_flit (front_flit[gi]),
                .credit_ret (in_credit[gi])
            );
            assign front_last[gi] = front_flit[gi][CLOSE_BIT];
        end
    endgenerate

    // Head requests: the OC field names this router's output.
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                head_req[o][i] = front_valid[i] && front_flit[i][OPEN_BIT] &&
                                 (front_flit[i][PORT_W-1:0] == PORT_W'(o));
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            pop[i] = 1'b0;
            for (int o = 0; o < NPORT; o++) begin
                if (send[o] && sel[o] == PORT_W'(i)) begin
                    pop[i] = 1'b1;
                end
            end
        end
    end

    // Stage two: arbitration, crossbar, lookahead and output register.
    generate
        for (genvar go = 0; go < NPORT; go++) begin : g_out
            wh_out_ctrl #(.NIN(NPORT), .CRED_MAX(DOWN_DEPTH)) u_ctrl (
                .clk        (clk),
                .rst_n      (rst_n),
                .head_req   (head_req[go]),
                .front_valid(front_valid),
                .front_last (front_last),
                .credit_ret (out_credit[go]),
                .send       (send[go]),
                .sel        (sel[go])
            );

            always_comb begin
                xbar_flit[go] = '0;
                for (int i = 0; i < NPORT; i++) begin
                    if (sel[go] == PORT_W'(i)) begin
                        xbar_flit[go] = front_flit[i];
                    end
                end
            end

            wh_lookahead #(.OUT_PORT(go), .MY_X(MY_X), .MY_Y(MY_Y)) u_la (
                .flit_in (xbar_flit[go]),
                .flit_out(la_flit[go])
            );

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid[go]                  <= 1'b0;
                    out_flit[go*FLIT_W +: FLIT_W] <= '0;
                end else begin
                    out_valid[go] <= send[go];
                    if (send[go]) begin
                        out_flit[go*FLIT_W +: FLIT_W] <= la_flit[go];
                    end
                end
            end
        end
    endgenerate

    // R3: every grant on an output removes exactly one queued flit
    assert_pop_matches_send_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pop) == $countones(send));

    // R8: input credit pulses line up with flits leaving the router
    assert_credit_tracks_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(in_credit) == $countones(out_valid));

    // R4: a head ejected locally carries output code 0
    assert_local_oc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[0] && out_flit[OPEN_BIT]) |-> out_flit[PORT_W-1:0] == PORT_LOCAL);

endmodule

// File: tb/wh_router2_bench.sv
module wh_router2_bench;

    localparam int NP = 5;
    localparam int FW = 18;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NP-1:0]    in_valid;
    logic [NP*FW-1:0] in_flit;
    logic [NP-1:0]    in_credit;
    logic [NP-1:0]    out_valid;
    logic [NP*FW-1:0] out_flit;
    logic [NP-1:0]    out_credit;

    int        n_checks = 0;
    int        n_fail   = 0;
    bit        auto_ret = 1'b1;
    bit        done     = 1'b0;
    logic [NP-1:0] man_ret = '0;

    always #10 clk = ~clk;

    wh_router2 #(.MY_X(1), .MY_Y(1), .BUF_DEPTH(4), .DOWN_DEPTH(4)) u_wh_router2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_flit   (in_flit),
        .in_credit (in_credit),
        .out_valid (out_valid),
        .out_flit  (out_flit),
        .out_credit(out_credit)
    );

    task automatic tick();
        @(negedge clk);
        out_credit = (auto_ret ? out_valid : '0) | man_ret;
        man_ret    = '0;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] mkflit(input logic [1:0] kind, input int oc,
                                             input int dx, input int dy, input int tag);
        logic [8:0] t;
        logic [1:0] x;
        logic [1:0] y;
        logic [2:0] c;
        t = tag[8:0];
        x = dx[1:0];
        y = dy[1:0];
        c = oc[2:0];
        return {kind, t, y, x, c};
    endfunction

    // X-then-Y decision from signed offsets.
    function automatic int exp_route(input int cx, input int cy, input int dx, input int dy);
        int ox;
        int oy;
        ox = dx - cx;
        oy = dy - cy;
        if (ox > 0) return 1;
        if (ox < 0) return 2;
        if (oy > 0) return 3;
        if (oy < 0) return 4;
        return 0;
    endfunction

    function automatic int exp_next_oc(input int port, input int dx, input int dy);
        int nx;
        int ny;
        if (port == 0) return 0;
        nx = 1 + ((port == 1) ? 1 : 0) - ((port == 2) ? 1 : 0);
        ny = 1 + ((port == 3) ? 1 : 0) - ((port == 4) ? 1 : 0);
        return exp_route(nx, ny, dx, dy);
    endfunction

    function automatic logic [FW-1:0] out_at(input int p);
        return out_flit[p*FW +: FW];
    endfunction

    task automatic drive(input int p, input logic [FW-1:0] f);
        in_valid[p]        = 1'b1;
        in_flit[p*FW +: FW] = f;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [FW-1:0] pa [3];
        logic [FW-1:0] pb [3];
        logic [FW-1:0] pe [6];
        logic [FW-1:0] ps [4];
        logic [FW-1:0] pk [4];
        int cnt;
        int cred_cnt;

        rst_n      = 1'b0;
        in_valid   = '0;
        in_flit    = '0;
        out_credit = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "out_valid in reset", 32'(out_valid), 32'h0);
        check("R1", "in_credit in reset", 32'(in_credit), 32'h0);
        rst_n = 1'b1;
        tick();
        check("R1", "out_valid after reset", 32'(out_valid), 32'h0);
        check("R1", "in_credit after reset", 32'(in_credit), 32'h0);

        // Sweep: each input, every destination of a 3x3 mesh (R2, R3, R4, R8).
        for (int i = 0; i < NP; i++) begin
            for (int dy = 0; dy < 3; dy++) begin
                for (int dx = 0; dx < 3; dx++) begin
                    int oc;
                    int tag;
                    logic [FW-1:0] f;
                    tag = i * 9 + dy * 3 + dx;
                    oc  = exp_route(1, 1, dx, dy);
                    tick();
                    drive(i, mkflit(2'b11, oc, dx, dy, tag));
                    tick();
                    in_valid = '0;
                    tick();
                    f = out_at(oc);
                    check("R3", "output port select", 32'(out_valid), 32'(1 << oc));
                    check("R8", "input credit pulse", 32'(in_credit), 32'(1 << i));
                    check("R2", "payload after two cycles", 32'(f[FW-1:3]),
                          32'({2'b11, tag[8:0], dy[1:0], dx[1:0]}));
                    check("R4", "lookahead output code", 32'(f[2:0]),
                          32'(exp_next_oc(oc, dx, dy)));
                    tick();
                end
            end
        end

        // Two 3-flit packets to local: R5 hold and R6 order (last grant on local was input 4).
        pa[0] = mkflit(2'b01, 0, 1, 1, 100);
        pa[1] = {2'b00, 16'hA001};
        pa[2] = {2'b10, 16'hA002};
        pb[0] = mkflit(2'b01, 0, 1, 1, 200);
        pb[1] = {2'b00, 16'hB001};
        pb[2] = {2'b10, 16'hB002};
        for (int s = 0; s < 9; s++) begin
            tick();
            in_valid = '0;
            if (s < 3) begin
                drive(1, pa[s]);
                drive(2, pb[s]);
            end
            if (s >= 2 && s <= 4) begin
                check("R5", "first packet flit", 32'(out_at(0)), 32'(pa[s-2]));
                check("R6", "first packet valid", 32'(out_valid), 32'h1);
            end else if (s >= 5 && s <= 7) begin
                check("R5", "second packet flit", 32'(out_at(0)), 32'(pb[s-5]));
                check("R5", "second packet valid", 32'(out_valid), 32'h1);
            end else if (s == 8) begin
                check("R5", "local idle after tails", 32'(out_valid), 32'h0);
            end
        end

        // Three singles to local at once: R6 order 3,4,1 and R10 back-to-back.
        tick();
        drive(1, mkflit(2'b11, 0, 1, 1, 31));
        drive(3, mkflit(2'b11, 0, 1, 1, 33));
        drive(4, mkflit(2'b11, 0, 1, 1, 34));
        tick();
        in_valid = '0;
        tick();
        check("R6", "rr first winner", 32'(out_at(0)), 32'(mkflit(2'b11, 0, 1, 1, 33)));
        check("R10", "rr first valid", 32'(out_valid[0]), 32'h1);
        tick();
        check("R6", "rr second winner", 32'(out_at(0)), 32'(mkflit(2'b11, 0, 1, 1, 34)));
        check("R10", "rr second valid", 32'(out_valid[0]), 32'h1);
        tick();
        check("R6", "rr third winner", 32'(out_at(0)), 32'(mkflit(2'b11, 0, 1, 1, 31)));
        check("R10", "rr third valid", 32'(out_valid[0]), 32'h1);
        tick();
        tick();

        // Credit starvation on east (R7): 6-flit packet, 4 credits, manual returns.
        auto_ret = 1'b0;
        pe[0] = mkflit(2'b01, 1, 2, 1, 300);
        for (int k = 1; k < 5; k++) pe[k] = {2'b00, 16'(16'hC000 + k)};
        pe[5] = {2'b10, 16'hC005};
        cnt = 0;
        for (int s = 0; s < 12; s++) begin
            tick();
            in_valid = '0;
            if (s < 6) drive(0, pe[s]);
            if (out_valid[1]) begin
                logic [FW-1:0] e;
                e = (cnt == 0) ? mkflit(2'b01, 0, 2, 1, 300) : pe[cnt];
                check("R7", "east flit in order", 32'(out_at(1)), 32'(e));
                cnt++;
            end
        end
        check("R7", "flits sent on four credits", 32'(cnt), 32'd4);
        for (int r = 4; r < 6; r++) begin
            man_ret = 5'b00010;
            tick();
            tick();
            check("R7", "no send before credit lands", 32'(out_valid[1]), 32'h0);
            tick();
            check("R7", "resume after credit", 32'(out_valid[1]), 32'h1);
            check("R7", "resumed flit", 32'(out_at(1)), 32'(pe[r]));
        end
        for (int r = 0; r < 4; r++) begin
            man_ret = 5'b00010;
            tick();
        end
        tick();

        // Full queue behind a starved south output (R9, R8).
        for (int k = 0; k < 4; k++) ps[k] = mkflit(2'b11, 4, 1, 0, 400 + k);
        pk[0] = mkflit(2'b01, 4, 1, 0, 500);
        pk[1] = {2'b00, 16'hD001};
        pk[2] = {2'b00, 16'hD002};
        pk[3] = {2'b10, 16'hD003};
        cnt = 0;
        cred_cnt = 0;
        for (int s = 0; s < 12; s++) begin
            tick();
            in_valid = '0;
            if (s < 4) drive(0, ps[s]);
            else if (s < 8) drive(3, pk[s-4]);
            if (out_valid[4]) begin
                check("R9", "single before stall", 32'(out_at(4)),
                      32'(mkflit(2'b11, 0, 1, 0, 400 + cnt)));
                cnt++;
            end
            if (in_credit[3]) cred_cnt++;
        end
        check("R7", "singles use all credits", 32'(cnt), 32'd4);
        check("R8", "no credit while queue blocked", 32'(cred_cnt), 32'd0);
        cnt = 0;
        cred_cnt = 0;
        for (int s = 0; s < 12; s++) begin
            tick();
            if (s < 4) man_ret = 5'b10000;
            if (out_valid[4]) begin
                logic [FW-1:0] e;
                e = (cnt == 0) ? mkflit(2'b01, 0, 1, 0, 500) : pk[cnt];
                check("R9", "queued flit order", 32'(out_at(4)), 32'(e));
                cnt++;
            end
            if (in_credit[3]) cred_cnt++;
        end
        check("R9", "queued flits released", 32'(cnt), 32'd4);
        check("R8", "credit pulses for queued flits", 32'(cred_cnt), 32'd4);
        for (int r = 0; r < 4; r++) begin
            man_ret = 5'b10000;
            tick();
        end
        tick();
        tick();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule